// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block carries out the state update a 32-bit processor core makes when it takes an exception. The core presents a one-cycle request strobe together with the exception type code, a 32-bit flags word, a 32-bit fault address and its current PC, next PC and MSR. For a supported type the unit does the following on the next clock edge:

- It captures a return address into save/restore register 0.
- It captures a filtered copy of the machine state into save/restore register 1.
- For data storage faults only, it records the fault address and fault status.
- It latches the vector and acknowledges.

The acknowledge tells the core to clear its MSR and resume fetch at the vector. A flush pulse tells the translation buffers to drop their entries.

Unsupported type codes are refused with a reject pulse, and every held register keeps its value. All saved registers are visible on dedicated output ports. Choosing between simultaneous exceptions and returning from an interrupt are handled elsewhere.

Top module: `exc_entry_unit`

## Requirements
- R1: While reset is applied and until the first accepted request, every output is zero.
- R2: On acceptance, the saved state `srr1_o` becomes `msr_i & 0x87C0FFFF`. Three types add bits on top of that value. Type 0x400 (instruction storage) and type 0x700 (program) OR in `flags_i`. Type 0x200 (machine check) ORs in the recoverable bit 0x2.
- R3: On acceptance, `srr0_o` takes `npc_i` in two cases: for type 0xC00 (system call), and for type 0x700 when bit 16 (0x0001_0000) of `flags_i` is set. In every other case it takes `pc_i`.
- R4: Type 0x300 (data storage) loads `dar_o` from `addr_i` and `dsisr_o` from `flags_i`. No other type changes these two registers.
- R5: The supported codes are 0x200, 0x300, 0x400, 0x500, 0x700, 0x800, 0x900, 0xC00, 0xD00, 0xE00 and 0xF20. When a request with one of these codes is accepted, `vector_o` takes the code zero-extended. `ack_o` then instructs the core to write zero to its MSR and to fetch from `vector_o`.
- R6: Each accepted request raises `tlb_flush_o` for exactly one cycle, and in the same cycle as `ack_o`.
- R7: A request with any other code raises `nack_o` for one cycle and leaves all of the following unchanged: `srr0_o`, `srr1_o`, `dar_o`, `dsisr_o` and `vector_o`. `ack_o` and `nack_o` are never high together.
- R8: A machine check taken while MSR bit 12 (0x1000) is clear raises `me_err_o` alongside `ack_o`. The request is still accepted.
- R9: The response and the register updates appear in the cycle after the request is sampled. Requests on consecutive cycles are each handled on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Exception request strobe |
| type_i | input | 12 | Exception type / vector offset |
| flags_i | input | 32 | Flags word |
| addr_i | input | 32 | Faulting data address |
| pc_i | input | 32 | Current PC |
| npc_i | input | 32 | Next PC |
| msr_i | input | 32 | Current MSR |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved machine state |
| dar_o | output | 32 | Fault address register |
| dsisr_o | output | 32 | Fault status register |
| vector_o | output | 32 | Fetch redirect target |
| ack_o | output | 1 | Request accepted; clear MSR, redirect |
| nack_o | output | 1 | Request rejected |
| tlb_flush_o | output | 1 | Translation flush pulse |
| me_err_o | output | 1 | Machine check with checks disabled |

## Verification
Every result of this block is due one clock edge after the request is sampled. This covers the four saved registers, the vector, and the acknowledge, reject, flush and error pulses.

The bench drives each request on a falling edge and advances its behavioural model for that same request. It then waits for the next rising edge and compares every output 1 ns later. A held register therefore matches the model's earlier value until an accepted request changes it, and each pulse is checked in exactly its one valid cycle.

The bench runs long streams of back-to-back and idle cycles. This shows that pulses never linger and that rejected or foreign types leave the fault registers untouched.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int unsigned NUM_KINDS = 11;
  localparam int unsigned CODE_W    = 12;

  localparam logic [31:0] SAVE_KEEP_MASK = 32'h87C0_FFFF;
  localparam logic [31:0] RECOV_BIT      = 32'h0000_0002;
  localparam int unsigned MCHK_EN_POS    = 12;

  typedef enum logic [3:0] {
    K_MCHK  = 4'd0,
    K_DSTOR = 4'd1,
    K_ISTOR = 4'd2,
    K_EXTI  = 4'd3,
    K_PROG  = 4'd4,
    K_FPOFF = 4'd5,
    K_DECR  = 4'd6,
    K_SCALL = 4'd7,
    K_TRACE = 4'd8,
    K_FPAST = 4'd9,
    K_VECOF = 4'd10,
    K_NONE  = 4'd15
  } exc_kind_e;

  typedef struct packed {
    logic valid;
    logic ret_next;
    logic ret_next_cond;
    logic merge_flags;
    logic merge_recov;
    logic load_fault;
    logic check_mchk_en;
  } exc_ctl_t;

  function automatic logic [CODE_W-1:0] kind_code(input int unsigned idx);
    logic [CODE_W-1:0] c;
    case (idx)
      0:       c = 12'h200;
      1:       c = 12'h300;
      2:       c = 12'h400;
      3:       c = 12'h500;
      4:       c = 12'h700;
      5:       c = 12'h800;
      6:       c = 12'h900;
      7:       c = 12'hC00;
      8:       c = 12'hD00;
      9:       c = 12'hE00;
      default: c = 12'hF20;
    endcase
    return c;
  endfunction

  function automatic exc_ctl_t kind_ctl(input exc_kind_e k);
    exc_ctl_t c;
    c = '0;
    c.valid = (k != K_NONE);
    case (k)
      K_MCHK:  begin c.merge_recov = 1'b1; c.check_mchk_en = 1'b1; end
      K_DSTOR: c.load_fault = 1'b1;
      K_ISTOR: c.merge_flags = 1'b1;
      K_PROG:  begin c.merge_flags = 1'b1; c.ret_next_cond = 1'b1; end
      K_SCALL: c.ret_next = 1'b1;
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/exc_type_decode.sv
module exc_type_decode
  import exc_entry_pkg::*;
#(
  parameter int unsigned TYPE_W = 12
) (
  input  logic [TYPE_W-1:0] type_i,
  output exc_kind_e         kind_o,
  output exc_ctl_t          ctl_o
);

  localparam int unsigned HIT_W = NUM_KINDS;

  logic [HIT_W-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_KINDS; gi++) begin : g_match
      localparam logic [TYPE_W-1:0] CODE = TYPE_W'(kind_code(gi));
      assign hit[gi] = (type_i == CODE);
    end
  endgenerate

  always_comb begin
    kind_o = K_NONE;
    for (int i = 0; i < NUM_KINDS; i++) begin
      if (hit[i]) kind_o = exc_kind_e'(4'(i));
    end
    ctl_o = kind_ctl(kind_o);
  end

endmodule

// File: rtl/exc_save_calc.sv
module exc_save_calc
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN          = 32,
  parameter int unsigned PROG_NEXT_BIT = 16
) (
  input  exc_ctl_t          ctl_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   npc_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [XLEN-1:0]   flags_i,
  output logic [XLEN-1:0]   srr0_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic              mchk_off_o
);

  localparam logic [XLEN-1:0] KEEP  = XLEN'(SAVE_KEEP_MASK);
  localparam logic [XLEN-1:0] RECOV = XLEN'(RECOV_BIT);

  logic use_next;
  logic [XLEN-1:0] base_state;
  logic [XLEN-1:0] extra_bits;

  always_comb begin
    use_next = ctl_i.ret_next | (ctl_i.ret_next_cond & flags_i[PROG_NEXT_BIT]);
    srr0_o   = use_next ? npc_i : pc_i;

    base_state = msr_i & KEEP;
    extra_bits = '0;
    if (ctl_i.merge_flags) extra_bits = extra_bits | flags_i;
    if (ctl_i.merge_recov) extra_bits = extra_bits | RECOV;
    srr1_o = base_state | extra_bits;

    mchk_off_o = ctl_i.check_mchk_en & ~msr_i[MCHK_EN_POS];
  end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned TYPE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  exc_ctl_t          ctl_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [XLEN-1:0]   srr0_d_i,
  input  logic [XLEN-1:0]   srr1_d_i,
  input  logic [XLEN-1:0]   addr_i,
  input  logic [XLEN-1:0]   flags_i,
  input  logic              mchk_off_i,
  output logic [XLEN-1:0]   srr0_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic [XLEN-1:0]   dar_o,
  output logic [XLEN-1:0]   dsisr_o,
  output logic [XLEN-1:0]   vector_o,
  output logic              ack_o,
  output logic              nack_o,
  output logic              flush_o,
  output logic              mchk_err_o
);

  logic save_en, fault_en;
  logic ack_d, nack_d, flush_d, err_d;
  logic [XLEN-1:0] vec_d;

  logic [XLEN-1:0] srr0_q, srr1_q, dar_q, dsisr_q, vec_q;
  logic ack_q, nack_q, flush_q, err_q;

  always_comb begin
    save_en  = req_i & ctl_i.valid;
    fault_en = save_en & ctl_i.load_fault;
    ack_d    = save_en;
    nack_d   = req_i & ~ctl_i.valid;
    flush_d  = save_en;
    err_d    = save_en & mchk_off_i;
    vec_d    = XLEN'(type_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srr0_q  <= '0;
      srr1_q  <= '0;
      vec_q   <= '0;
    end else if (save_en) begin
      srr0_q  <= srr0_d_i;
      srr1_q  <= srr1_d_i;
      vec_q   <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dar_q   <= '0;
      dsisr_q <= '0;
    end else if (fault_en) begin
      dar_q   <= addr_i;
      dsisr_q <= flags_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q   <= 1'b0;
      nack_q  <= 1'b0;
      flush_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ack_q   <= ack_d;
      nack_q  <= nack_d;
      flush_q <= flush_d;
      err_q   <= err_d;
    end
  end

  assign srr0_o     = srr0_q;
  assign srr1_o     = srr1_q;
  assign dar_o      = dar_q;
  assign dsisr_o    = dsisr_q;
  assign vector_o   = vec_q;
  assign ack_o      = ack_q;
  assign nack_o     = nack_q;
  assign flush_o    = flush_q;
  assign mchk_err_o = err_q;

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int unsigned XLEN          = 32,
  parameter int unsigned TYPE_W        = 12,
  parameter int unsigned PROG_NEXT_BIT = 16,
  parameter int unsigned RST_STAGES    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [XLEN-1:0]   flags_i,
  input  logic [XLEN-1:0]   addr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   npc_i,
  input  logic [XLEN-1:0]   msr_i,
  output logic [XLEN-1:0]   srr0_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic [XLEN-1:0]   dar_o,
  output logic [XLEN-1:0]   dsisr_o,
  output logic [XLEN-1:0]   vector_o,
  output logic              ack_o,
  output logic              nack_o,
  output logic              tlb_flush_o,
  output logic              me_err_o
);

  localparam int unsigned SYNC_W = (RST_STAGES < 1) ? 1 : RST_STAGES;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_W-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_W-2 >= 0 ? SYNC_W-2 : 0 : 0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_W-1];

  exc_kind_e kind;
  exc_ctl_t  ctl;
  logic [XLEN-1:0] srr0_d, srr1_d;
  logic            mchk_off;

  exc_type_decode #(.TYPE_W(TYPE_W)) u_decode (
    .type_i (type_i),
    .kind_o (kind),
    .ctl_o  (ctl)
  );

  exc_save_calc #(.XLEN(XLEN), .PROG_NEXT_BIT(PROG_NEXT_BIT)) u_calc (
    .ctl_i      (ctl),
    .pc_i       (pc_i),
    .npc_i      (npc_i),
    .msr_i      (msr_i),
    .flags_i    (flags_i),
    .srr0_o     (srr0_d),
    .srr1_o     (srr1_d),
    .mchk_off_o (mchk_off)
  );

  exc_state_regs #(.XLEN(XLEN), .TYPE_W(TYPE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_i      (req_i),
    .ctl_i      (ctl),
    .type_i     (type_i),
    .srr0_d_i   (srr0_d),
    .srr1_d_i   (srr1_d),
    .addr_i     (addr_i),
    .flags_i    (flags_i),
    .mchk_off_i (mchk_off),
    .srr0_o     (srr0_o),
    .srr1_o     (srr1_o),
    .dar_o      (dar_o),
    .dsisr_o    (dsisr_o),
    .vector_o   (vector_o),
    .ack_o      (ack_o),
    .nack_o     (nack_o),
    .flush_o    (tlb_flush_o),
    .mchk_err_o (me_err_o)
  );

  logic unused_kind;
  assign unused_kind = ^kind;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned TYPE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [TYPE_W-1:0] type_i,
  input logic [XLEN-1:0]   npc_i,
  input logic [XLEN-1:0]   msr_i,
  input logic [XLEN-1:0]   srr0_o,
  input logic [XLEN-1:0]   srr1_o,
  input logic [XLEN-1:0]   dar_o,
  input logic [XLEN-1:0]   dsisr_o,
  input logic [XLEN-1:0]   vector_o,
  input logic              ack_o,
  input logic              nack_o,
  input logic              tlb_flush_o,
  input logic              me_err_o
);

  localparam logic [XLEN-1:0]   KEEP   = XLEN'(32'h87C0_FFFF);
  localparam logic [TYPE_W-1:0] T_MCHK = TYPE_W'(12'h200);
  localparam logic [TYPE_W-1:0] T_DST  = TYPE_W'(12'h300);
  localparam logic [TYPE_W-1:0] T_EXT  = TYPE_W'(12'h500);
  localparam logic [TYPE_W-1:0] T_SC   = TYPE_W'(12'hC00);

  p_flush_with_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> tlb_flush_o);
  p_flush_only_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush_o |-> ack_o);
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_o && nack_o));
  p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> ($stable(srr0_o) && $stable(srr1_o) && $stable(dar_o)
                && $stable(dsisr_o) && $stable(vector_o)));
  p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (vector_o == XLEN'($past(type_i))));
  p_ext_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(type_i) == T_EXT) |-> (srr1_o == ($past(msr_i) & KEEP)));
  p_scall_npc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(type_i) == T_SC) |-> (srr0_o == $past(npc_i)));
  p_fault_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(type_i) != T_DST) |-> ($stable(dar_o) && $stable(dsisr_o)));
  p_mchk_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    me_err_o |-> (ack_o && $past(type_i) == T_MCHK && !$past(msr_i[12])));
  p_resp_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o || nack_o) |-> $past(req_i));

endmodule

bind exc_entry_unit exc_entry_chk #(.XLEN(XLEN), .TYPE_W(TYPE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .type_i      (type_i),
  .npc_i       (npc_i),
  .msr_i       (msr_i),
  .srr0_o      (srr0_o),
  .srr1_o      (srr1_o),
  .dar_o       (dar_o),
  .dsisr_o     (dsisr_o),
  .vector_o    (vector_o),
  .ack_o       (ack_o),
  .nack_o      (nack_o),
  .tlb_flush_o (tlb_flush_o),
  .me_err_o    (me_err_o)
);

// File: tb/exc_entry_unit_tb_top.sv
`timescale 1ns/1ps
module exc_entry_unit_tb_top;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic [11:0] typ;
  logic [31:0] flags, addr, pc, npc, msr;
  logic [31:0] srr0, srr1, dar, dsisr, vec;
  logic        ack, nack, flush, merr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // model state
  logic [31:0] m_srr0 = 0, m_srr1 = 0, m_dar = 0, m_dsisr = 0, m_vec = 0;
  logic        m_ack = 0, m_nack = 0, m_merr = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  exc_entry_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .type_i(typ), .flags_i(flags),
    .addr_i(addr), .pc_i(pc), .npc_i(npc), .msr_i(msr),
    .srr0_o(srr0), .srr1_o(srr1), .dar_o(dar), .dsisr_o(dsisr),
    .vector_o(vec), .ack_o(ack), .nack_o(nack), .tlb_flush_o(flush),
    .me_err_o(merr)
  );

  function automatic bit known(input logic [11:0] t);
    case (t)
      12'h200, 12'h300, 12'h400, 12'h500, 12'h700, 12'h800,
      12'h900, 12'hC00, 12'hD00, 12'hE00, 12'hF20: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %08h expected %08h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    cmp("R3", {tag, " srr0"}, srr0, m_srr0);
    cmp("R2", {tag, " srr1"}, srr1, m_srr1);
    cmp("R4", {tag, " dar"}, dar, m_dar);
    cmp("R4", {tag, " dsisr"}, dsisr, m_dsisr);
    cmp("R5", {tag, " vector"}, vec, m_vec);
    cmp("R9", {tag, " ack"}, {31'd0, ack}, {31'd0, m_ack});
    cmp("R7", {tag, " nack"}, {31'd0, nack}, {31'd0, m_nack});
    cmp("R6", {tag, " flush"}, {31'd0, flush}, {31'd0, m_ack});
    cmp("R8", {tag, " me_err"}, {31'd0, merr}, {31'd0, m_merr});
  endtask

  // one cycle: drive on falling edge, model, compare 1 ns after rising edge
  task automatic step(input string tag, input bit r, input logic [11:0] t,
                      input logic [31:0] f, input logic [31:0] a,
                      input logic [31:0] p, input logic [31:0] np,
                      input logic [31:0] m);
    @(negedge clk);
    req = r; typ = t; flags = f; addr = a; pc = p; npc = np; msr = m;
    m_ack = 0; m_nack = 0; m_merr = 0;
    if (r && known(t)) begin
      m_ack = 1;
      m_vec = {20'd0, t};
      m_srr0 = (t == 12'hC00 || (t == 12'h700 && f[16])) ? np : p;
      m_srr1 = m & 32'h87C0FFFF;
      if (t == 12'h400 || t == 12'h700) m_srr1 = m_srr1 | f;
      if (t == 12'h200) begin
        m_srr1 = m_srr1 | 32'h2;
        m_merr = ~m[12];
      end
      if (t == 12'h300) begin m_dar = a; m_dsisr = f; end
    end else if (r) begin
      m_nack = 1;
    end
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step("idle", 0, 12'h000, 0, 0, 0, 0, 0);
  endtask

  initial begin
    req = 0; typ = 0; flags = 0; addr = 0; pc = 0; npc = 0; msr = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1 reset");
    @(negedge clk); rst_n = 1;
    idle(4);
    compare_all("R1 after release");

    // R2 masking, external
    step("R2 ext", 1, 12'h500, 32'hFFFF_FFFF, 32'h1, 32'h1000_0000, 32'h1000_0004, 32'hFFFF_FFFF);
    // R4 data storage
    step("R4 dstor", 1, 12'h300, 32'h4200_0000, 32'hDEAD_BEE0, 32'h2000, 32'h2004, 32'h0000_9032);
    // R4 not touched by istor; R2 merge flags
    step("R2 istor", 1, 12'h400, 32'h4000_0000, 32'h1234_5678, 32'h3000, 32'h3004, 32'h0000_B032);
    // R3 syscall saves npc
    step("R3 scall", 1, 12'hC00, 0, 0, 32'h4000, 32'h4004, 32'h0000_D032);
    // R3 program with next bit / without
    step("R3 prog next", 1, 12'h700, 32'h0001_0000, 0, 32'h5000, 32'h5004, 32'h0000_1000);
    step("R3 prog cur", 1, 12'h700, 32'h0002_0000, 0, 32'h6000, 32'h6004, 32'h0000_1000);
    // R8 machine check with / without enable
    step("R8 mchk off", 1, 12'h200, 0, 0, 32'h7000, 32'h7004, 32'h0000_0030);
    step("R8 mchk on", 1, 12'h200, 0, 0, 32'h7100, 32'h7104, 32'h0000_1030);
    // R7 reject, state held
    step("R7 bad", 1, 12'h600, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000, 32'h8004, 32'hFFFF_FFFF);
    step("R7 bad2", 1, 12'hF00, 32'h1, 32'h1, 32'h8100, 32'h8104, 32'h1);
    idle(2);
    // R5 every supported code back-to-back (R9)
    step("R5 fpoff", 1, 12'h800, 0, 0, 32'hA0, 32'hA4, 32'h0000_2000);
    step("R5 decr", 1, 12'h900, 0, 0, 32'hB0, 32'hB4, 32'h0000_8000);
    step("R5 trace", 1, 12'hD00, 0, 0, 32'hC0, 32'hC4, 32'h0000_0400);
    step("R5 fpast", 1, 12'hE00, 0, 0, 32'hD0, 32'hD4, 32'h0200_0000);
    step("R5 vecoff", 1, 12'hF20, 0, 0, 32'hE0, 32'hE4, 32'h8000_0000);
    idle(1);

    // random stream
    for (int i = 0; i < 400; i++) begin
      logic [11:0] t;
      int sel;
      sel = $urandom_range(0, 13);
      case (sel)
        0: t = 12'h200;  1: t = 12'h300;  2: t = 12'h400;  3: t = 12'h500;
        4: t = 12'h700;  5: t = 12'h800;  6: t = 12'h900;  7: t = 12'hC00;
        8: t = 12'hD00;  9: t = 12'hE00; 10: t = 12'hF20;
        default: t = 12'($urandom);
      endcase
      step("R9 random", ($urandom_range(0, 3) != 0), t, $urandom, $urandom,
           $urandom, $urandom, $urandom);
    end
    idle(2);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule